// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the general-purpose register file of a small RISC core. Software sees sixteen 32-bit registers, R0 to R15. The upper eight are single physical registers. The lower eight exist twice, as bank 0 and bank 1. Which bank stands behind R0 to R7 at any moment is set by two bits of a small status slice: a privilege bit and a bank-select bit.

The core reads operands through two combinational read ports and writes results through one write port. A separate alternate port reads and writes the lower registers of whichever bank is currently hidden. Software uses it to save and restore the other context, and it works only in privileged mode. The status slice also holds an interrupt-block bit and a 4-bit interrupt mask. It is loaded through a single write strobe.

Top module: `banked_regfile`

## Requirements
- R1: Indices 8 to 15 on the read and write ports address eight shared 32-bit registers, and the same register is seen whatever the privilege and bank bits hold. Both read ports return the addressed register combinationally.
- R2: When sr_mode=1 and sr_bank=1, indices 0 to 7 on the normal ports address bank 1, and the alternate port addresses bank 0.
- R3: When sr_mode=1 and sr_bank=0, indices 0 to 7 on the normal ports address bank 0, and the alternate port addresses bank 1.
- R4: When sr_mode=0 (user), indices 0 to 7 on the normal ports address bank 0 whatever sr_bank holds.
- R5: Reset (rst_n low, asynchronous) sets sr_mode=1, sr_bank=1, sr_block=1 and sr_mask=4'hF. The general registers keep no reset value.
- R6: A cycle with sr_wr_en=1 loads mode, block and mask from the write fields at the clock edge. The bank field is loaded only if sr_mode was 1 before that edge, and otherwise sr_bank keeps its value.
- R7: In user mode the alternate port is locked. A write through it changes no register, and alt_rd_data reads as zero.
- R8: illegal_access is 1 in the cycle after a cycle in which alt_rd_en or alt_wr_en was 1 with sr_mode=0, and it is 0 in every other cycle.
- R9: Writes take effect at the rising clock edge. A read in the same cycle as a write to the same register returns the old value.
- R10: When the status slice is written in a cycle, every register access in that cycle uses the mapping that held before the write. The new mapping applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port register index |
| wr_data | input | 32 | Write port data |
| alt_rd_en | input | 1 | Alternate-port read strobe |
| alt_rd_idx | input | 3 | Alternate-port read index (0 to 7) |
| alt_rd_data | output | 32 | Alternate-port read data |
| alt_wr_en | input | 1 | Alternate-port write enable |
| alt_wr_idx | input | 3 | Alternate-port write index (0 to 7) |
| alt_wr_data | input | 32 | Alternate-port write data |
| sr_wr_en | input | 1 | Status slice write strobe |
| sr_wr_mode | input | 1 | New privilege bit (1 = privileged) |
| sr_wr_bank | input | 1 | New bank-select bit |
| sr_wr_block | input | 1 | New interrupt-block bit |
| sr_wr_mask | input | 4 | New interrupt mask |
| sr_mode | output | 1 | Current privilege bit |
| sr_bank | output | 1 | Current bank-select bit |
| sr_block | output | 1 | Current interrupt-block bit |
| sr_mask | output | 4 | Current interrupt mask |
| illegal_access | output | 1 | One-cycle flag for an alternate access in user mode |

## Verification
The mapping is tried with the same index, R3, in all three status states: privileged with bank 1, privileged with bank 0, and user with the bank bit left at 1. The bank 0 and bank 1 copies hold different values, so a wrong bank choice shows at once. The shared index R9 is read in each state, which separates a register that is truly shared from one that is banked by mistake. A user-mode alternate write followed by a return to privileged mode shows whether the locked port touched either bank. It also shows whether the bank bit kept its value while in user mode. Directed cycles that write and read the same register, or change the status slice and use the registers in the same cycle, tell apart the old value or mapping from the new one.

// File: rtl/breg_pkg.sv
package breg_pkg;

   // Control word that selects the register mapping.
   typedef struct packed {
      logic priv;   // 1 = privileged, 0 = user
      logic bank;   // bank select, honoured only when priv = 1
   } bank_ctl_t;

   typedef enum logic {
      BANK_ZERO = 1'b0,
      BANK_ONE  = 1'b1
   } bank_id_e;

   // Bank that backs the low registers on the normal ports.
   function automatic bank_id_e visible_bank(input bank_ctl_t ctl);
      return (ctl.priv && ctl.bank) ? BANK_ONE : BANK_ZERO;
   endfunction

endpackage

// File: rtl/breg_status.sv
module breg_status
   import breg_pkg::*;
#(
   parameter int MASK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_mode,
   input  logic              wr_bank,
   input  logic              wr_block,
   input  logic [MASK_W-1:0] wr_mask,
   output bank_ctl_t         ctl,
   output logic              block,
   output logic [MASK_W-1:0] mask
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl.priv <= 1'b1;
         ctl.bank <= 1'b1;
         block    <= 1'b1;
         mask     <= '1;
      end else if (wr_en) begin
         ctl.priv <= wr_mode;
         block    <= wr_block;
         mask     <= wr_mask;
         // The bank bit is protected while in user mode.
         if (ctl.priv) begin
            ctl.bank <= wr_bank;
         end
      end
   end

endmodule

// File: rtl/breg_map.sv
module breg_map
   import breg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  bank_ctl_t ctl,
   input  logic      alt_rd_en,
   input  logic      alt_wr_en,
   output logic      act_bank,
   output logic      alt_bank,
   output logic      alt_ok,
   output logic      illegal_q
);

   logic bad_try;

   always_comb begin
      act_bank = visible_bank(ctl);
      alt_bank = ~act_bank;
      alt_ok   = ctl.priv;
      bad_try  = !ctl.priv && (alt_rd_en || alt_wr_en);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         illegal_q <= 1'b0;
      end else begin
         illegal_q <= bad_try;
      end
   end

endmodule

// File: rtl/breg_store.sv
module breg_store #(
   parameter int DATA_W   = 32,
   parameter int BANKED_N = 8,
   parameter int SHARED_N = 8,
   parameter int NBANK    = 2,
   localparam int IDX_W   = $clog2(BANKED_N + SHARED_N),
   localparam int BIDX_W  = $clog2(BANKED_N)
) (
   input  logic              clk,
   input  logic              act_bank,
   input  logic              alt_bank,
   input  logic              alt_ok,
   input  logic [IDX_W-1:0]  rd_a_idx,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0] rd_a_data,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BIDX_W-1:0] alt_rd_idx,
   output logic [DATA_W-1:0] alt_rd_data,
   input  logic              alt_wr_en,
   input  logic [BIDX_W-1:0] alt_wr_idx,
   input  logic [DATA_W-1:0] alt_wr_data
);

   logic [DATA_W-1:0] bank_flat   [NBANK][BANKED_N];
   logic [DATA_W-1:0] shared_flat [SHARED_N];

   // Banked entries: one register per (bank, entry).
   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      for (genvar e = 0; e < BANKED_N; e++) begin : g_ent
         logic [DATA_W-1:0] ent_q;
         logic              hit_main;
         logic              hit_alt;

         assign hit_main = wr_en && (wr_idx == IDX_W'(e)) && (act_bank == 1'(b));
         assign hit_alt  = alt_wr_en && alt_ok && (alt_wr_idx == BIDX_W'(e))
                           && (alt_bank == 1'(b));

         always_ff @(posedge clk) begin
            if (hit_main) begin
               ent_q <= wr_data;
            end else if (hit_alt) begin
               ent_q <= alt_wr_data;
            end
         end

         assign bank_flat[b][e] = ent_q;
      end
   end

   // Shared entries: a single copy seen from every mapping.
   for (genvar s = 0; s < SHARED_N; s++) begin : g_shr
      logic [DATA_W-1:0] shr_q;

      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IDX_W'(BANKED_N + s))) begin
            shr_q <= wr_data;
         end
      end

      assign shared_flat[s] = shr_q;
   end

   function automatic logic [DATA_W-1:0] pick(input logic [IDX_W-1:0] idx,
                                              input logic             bsel);
      logic [DATA_W-1:0] v;
      v = '0;
      for (int e = 0; e < BANKED_N; e++) begin
         if (idx == IDX_W'(e)) v = bank_flat[bsel][e];
      end
      for (int s = 0; s < SHARED_N; s++) begin
         if (idx == IDX_W'(BANKED_N + s)) v = shared_flat[s];
      end
      return v;
   endfunction

   always_comb begin
      rd_a_data   = pick(rd_a_idx, act_bank);
      rd_b_data   = pick(rd_b_idx, act_bank);
      alt_rd_data = '0;
      if (alt_ok) begin
         for (int e = 0; e < BANKED_N; e++) begin
            if (alt_rd_idx == BIDX_W'(e)) alt_rd_data = bank_flat[alt_bank][e];
         end
      end
   end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import breg_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int BANKED_N = 8,
   parameter int SHARED_N = 8,
   parameter int MASK_W   = 4,
   localparam int IDX_W   = $clog2(BANKED_N + SHARED_N),
   localparam int BIDX_W  = $clog2(BANKED_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              alt_rd_en,
   input  logic [BIDX_W-1:0] alt_rd_idx,
   output logic [DATA_W-1:0] alt_rd_data,
   input  logic              alt_wr_en,
   input  logic [BIDX_W-1:0] alt_wr_idx,
   input  logic [DATA_W-1:0] alt_wr_data,
   input  logic              sr_wr_en,
   input  logic              sr_wr_mode,
   input  logic              sr_wr_bank,
   input  logic              sr_wr_block,
   input  logic [MASK_W-1:0] sr_wr_mask,
   output logic              sr_mode,
   output logic              sr_bank,
   output logic              sr_block,
   output logic [MASK_W-1:0] sr_mask,
   output logic              illegal_access
);

   localparam int NBANK = 2;

   // Elaboration-time parameter checks.
   if (DATA_W < 1) begin : g_bad_data_w
      $error("banked_regfile: DATA_W must be at least 1");
   end
   if (BANKED_N < 2) begin : g_bad_banked_n
      $error("banked_regfile: BANKED_N must be at least 2");
   end
   if (SHARED_N < 1) begin : g_bad_shared_n
      $error("banked_regfile: SHARED_N must be at least 1");
   end
   if (MASK_W < 1) begin : g_bad_mask_w
      $error("banked_regfile: MASK_W must be at least 1");
   end

   bank_ctl_t ctl;
   logic      act_bank;
   logic      alt_bank;
   logic      alt_ok;

   breg_status #(.MASK_W(MASK_W)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (sr_wr_en),
      .wr_mode  (sr_wr_mode),
      .wr_bank  (sr_wr_bank),
      .wr_block (sr_wr_block),
      .wr_mask  (sr_wr_mask),
      .ctl      (ctl),
      .block    (sr_block),
      .mask     (sr_mask)
   );

   breg_map u_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl),
      .alt_rd_en (alt_rd_en),
      .alt_wr_en (alt_wr_en),
      .act_bank  (act_bank),
      .alt_bank  (alt_bank),
      .alt_ok    (alt_ok),
      .illegal_q (illegal_access)
   );

   breg_store #(
      .DATA_W   (DATA_W),
      .BANKED_N (BANKED_N),
      .SHARED_N (SHARED_N),
      .NBANK    (NBANK)
   ) u_store (
      .clk         (clk),
      .act_bank    (act_bank),
      .alt_bank    (alt_bank),
      .alt_ok      (alt_ok),
      .rd_a_idx    (rd_a_idx),
      .rd_b_idx    (rd_b_idx),
      .rd_a_data   (rd_a_data),
      .rd_b_data   (rd_b_data),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .wr_data     (wr_data),
      .alt_rd_idx  (alt_rd_idx),
      .alt_rd_data (alt_rd_data),
      .alt_wr_en   (alt_wr_en),
      .alt_wr_idx  (alt_wr_idx),
      .alt_wr_data (alt_wr_data)
   );

   assign sr_mode = ctl.priv;
   assign sr_bank = ctl.bank;

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
   parameter int DATA_W   = 32,
   parameter int BANKED_N = 8,
   parameter int SHARED_N = 8,
   parameter int MASK_W   = 4,
   localparam int IDX_W   = $clog2(BANKED_N + SHARED_N),
   localparam int BIDX_W  = $clog2(BANKED_N)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [IDX_W-1:0]  rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              alt_rd_en,
   input logic [DATA_W-1:0] alt_rd_data,
   input logic              alt_wr_en,
   input logic              sr_wr_en,
   input logic              sr_mode,
   input logic              sr_bank,
   input logic              sr_block,
   input logic [MASK_W-1:0] sr_mask,
   input logic              illegal_access
);

   // High for the first clock edge after reset is released.
   logic first_edge;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) first_edge <= 1'b1;
      else        first_edge <= 1'b0;
   end

   // R5: status slice comes out of reset privileged, bank 1, blocked, mask all ones.
   a_r5_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      first_edge |-> (sr_mode && sr_bank && sr_block && (sr_mask == {MASK_W{1'b1}})));

   // R6: a status write in user mode leaves the bank bit alone.
   a_r6_bank_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_mode && sr_wr_en) |=> $stable(sr_bank));

   // R7: the locked alternate port reads as zero.
   a_r7_alt_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_mode && alt_rd_en) |-> (alt_rd_data == '0));

   // R8: the flag follows a user-mode alternate attempt by exactly one cycle.
   a_r8_illegal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (illegal_access == $past(!sr_mode && (alt_rd_en || alt_wr_en))));

   // R1: a shared register written is read back on the next cycle.
   a_r1_shared_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx >= IDX_W'(BANKED_N)))
      |=> ((rd_a_idx != $past(wr_idx)) || (rd_a_data == $past(wr_data))));

endmodule

bind banked_regfile banked_regfile_chk #(
   .DATA_W   (DATA_W),
   .BANKED_N (BANKED_N),
   .SHARED_N (SHARED_N),
   .MASK_W   (MASK_W)
) u_chk (.*);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 21;

   localparam logic [3:0] K_WR  = 4'd0;
   localparam logic [3:0] K_RD  = 4'd1;
   localparam logic [3:0] K_AWR = 4'd2;
   localparam logic [3:0] K_ARD = 4'd3;
   localparam logic [3:0] K_SR  = 4'd4;

   // {kind, index, data or expected value, requirement number}
   // K_SR: data[1] = new mode, data[0] = new bank.
   localparam logic [43:0] VEC [NVEC] = '{
      {K_WR,  4'd3,  32'hA1A1_0001, 4'd0},  // privileged, bank 1 active
      {K_RD,  4'd3,  32'hA1A1_0001, 4'd2},  // R2 normal port reaches bank 1
      {K_AWR, 4'd3,  32'hB0B0_0003, 4'd0},  // alternate write into bank 0
      {K_ARD, 4'd3,  32'hB0B0_0003, 4'd2},  // R2 alternate port reaches bank 0
      {K_WR,  4'd9,  32'hC9C9_0009, 4'd0},
      {K_RD,  4'd9,  32'hC9C9_0009, 4'd1},  // R1 shared register
      {K_SR,  4'd0,  32'h0000_0002, 4'd0},  // privileged, bank 0
      {K_RD,  4'd3,  32'hB0B0_0003, 4'd3},  // R3 normal port reaches bank 0
      {K_ARD, 4'd3,  32'hA1A1_0001, 4'd3},  // R3 alternate port reaches bank 1
      {K_RD,  4'd9,  32'hC9C9_0009, 4'd1},  // R1 shared after switch
      {K_WR,  4'd3,  32'hD3D3_0033, 4'd0},  // into bank 0
      {K_SR,  4'd0,  32'h0000_0001, 4'd0},  // user mode, bank bit 1
      {K_RD,  4'd3,  32'hD3D3_0033, 4'd4},  // R4 user mode sees bank 0
      {K_RD,  4'd9,  32'hC9C9_0009, 4'd1},  // R1 shared in user mode
      {K_ARD, 4'd3,  32'h0000_0000, 4'd7},  // R7 locked read is zero
      {K_AWR, 4'd3,  32'hEEEE_EEEE, 4'd0},  // locked write, must be dropped
      {K_SR,  4'd0,  32'h0000_0002, 4'd0},  // back to privileged, bank field 0 ignored
      {K_RD,  4'd3,  32'hA1A1_0001, 4'd6},  // R6 bank bit stayed 1, bank 1 intact
      {K_ARD, 4'd3,  32'hD3D3_0033, 4'd7},  // R7 bank 0 untouched by locked write
      {K_WR,  4'd15, 32'h0F0F_F0F0, 4'd0},
      {K_RD,  4'd15, 32'h0F0F_F0F0, 4'd1}   // R1 top shared register
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rd_a_idx = '0;
   logic [31:0] rd_a_data;
   logic [3:0]  rd_b_idx = '0;
   logic [31:0] rd_b_data;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic        alt_rd_en = 1'b0;
   logic [2:0]  alt_rd_idx = '0;
   logic [31:0] alt_rd_data;
   logic        alt_wr_en = 1'b0;
   logic [2:0]  alt_wr_idx = '0;
   logic [31:0] alt_wr_data = '0;
   logic        sr_wr_en = 1'b0;
   logic        sr_wr_mode = 1'b0;
   logic        sr_wr_bank = 1'b0;
   logic        sr_wr_block = 1'b0;
   logic [3:0]  sr_wr_mask = '0;
   logic        sr_mode;
   logic        sr_bank;
   logic        sr_block;
   logic [3:0]  sr_mask;
   logic        illegal_access;

   int n_checks = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   banked_regfile u_banked_regfile (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      wr_en = 1'b0; alt_rd_en = 1'b0; alt_wr_en = 1'b0; sr_wr_en = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
         $finish;
      end
   end

   initial begin
      // R5 reset state, while reset is held and after release.
      #(CLK_PERIOD * 2 + 1);
      check("R5 held", {28'd0, sr_mode, sr_bank, sr_block, 1'b0}, 32'hE);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R5 released", {24'd0, sr_mode, sr_bank, sr_block, 1'b0, sr_mask}, 32'hEF);
      check("R8 idle flag", {31'd0, illegal_access}, 32'd0);

      // Table of vectors.
      for (int i = 0; i < NVEC; i++) begin
         logic [3:0]  kind;
         logic [3:0]  idx;
         logic [31:0] dat;
         logic [3:0]  rq;
         {kind, idx, dat, rq} = VEC[i];
         @(negedge clk);
         idle();
         case (kind)
            K_WR:  begin wr_en = 1'b1; wr_idx = idx; wr_data = dat; end
            K_RD:  begin rd_a_idx = idx; rd_b_idx = idx; end
            K_AWR: begin alt_wr_en = 1'b1; alt_wr_idx = idx[2:0]; alt_wr_data = dat; end
            K_ARD: begin alt_rd_en = 1'b1; alt_rd_idx = idx[2:0]; end
            default: begin
               sr_wr_en = 1'b1; sr_wr_mode = dat[1]; sr_wr_bank = dat[0];
               sr_wr_block = 1'b1; sr_wr_mask = 4'hF;
            end
         endcase
         #1;
         if (kind == K_RD) begin
            check($sformatf("R%0d port A vec %0d", rq, i), rd_a_data, dat);
            check($sformatf("R%0d port B vec %0d", rq, i), rd_b_data, dat);
         end else if (kind == K_ARD) begin
            check($sformatf("R%0d alt vec %0d", rq, i), alt_rd_data, dat);
         end
      end
      @(negedge clk); idle();

      // R9: a read in the cycle of a write returns the old value.
      wr_en = 1'b1; wr_idx = 4'd10; wr_data = 32'h5555_0055;
      @(negedge clk);
      wr_data = 32'h6666_0066; rd_a_idx = 4'd10; #1;
      check("R9 old value", rd_a_data, 32'h5555_0055);
      @(negedge clk); idle(); #1;
      check("R9 new value", rd_a_data, 32'h6666_0066);

      // R10: status write and register use in one cycle (privileged, bank 1 now).
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'h1111_0011;
      alt_wr_en = 1'b1; alt_wr_idx = 3'd2; alt_wr_data = 32'h2222_0022;
      @(negedge clk); idle();
      sr_wr_en = 1'b1; sr_wr_mode = 1'b1; sr_wr_bank = 1'b0;
      sr_wr_block = 1'b1; sr_wr_mask = 4'hF;
      wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'h7777_0077;
      rd_a_idx = 4'd2; #1;
      check("R10 same-cycle read uses old bank", rd_a_data, 32'h1111_0011);
      @(negedge clk); idle(); alt_rd_en = 1'b1; alt_rd_idx = 3'd2; #1;
      check("R10 new mapping bank 0", rd_a_data, 32'h2222_0022);
      check("R10 same-cycle write hit old bank", alt_rd_data, 32'h7777_0077);

      // R8: privileged alternate read raises no flag.
      @(negedge clk); idle(); #1;
      check("R8 no flag when privileged", {31'd0, illegal_access}, 32'd0);

      // Enter user mode (bank 0 stays 0), then try the locked port.
      sr_wr_en = 1'b1; sr_wr_mode = 1'b0; sr_wr_bank = 1'b0;
      sr_wr_block = 1'b0; sr_wr_mask = 4'h3;
      @(negedge clk); idle(); alt_rd_en = 1'b1; alt_rd_idx = 3'd1;
      @(negedge clk); idle(); #1;
      check("R8 flag after user attempt", {31'd0, illegal_access}, 32'd1);
      @(negedge clk); #1;
      check("R8 flag drops", {31'd0, illegal_access}, 32'd0);

      // R6: user-mode status write loads mask and block but not the bank bit.
      sr_wr_en = 1'b1; sr_wr_mode = 1'b0; sr_wr_bank = 1'b1;
      sr_wr_block = 1'b0; sr_wr_mask = 4'h5;
      @(negedge clk); idle(); #1;
      check("R6 bank kept", {31'd0, sr_bank}, 32'd0);
      check("R6 fields loaded", {26'd0, sr_mode, sr_block, sr_mask}, 32'h05);

      // R5 again: reset from a changed state.
      @(negedge clk); rst_n = 1'b0; #1;
      check("R5 second reset", {24'd0, sr_mode, sr_bank, sr_block, 1'b0, sr_mask}, 32'hEF);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #1;
      check("R5 after release", {24'd0, sr_mode, sr_bank, sr_block, 1'b0, sr_mask}, 32'hEF);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
      $finish;
   end

endmodule